// File: doc/BRIEF.md
# Level-Duration Pulse Capture Unit

This block watches a single digital input and describes it as a stream of runs. Each run is a stretch of time during which the input holds one level. For each run the block records the level and the run's length. Lengths are counted in ticks of a timebase that a programmable divider derives from the base clock. Each record takes 16 bits. Two records are packed into every 32-bit output item, which leaves on a valid/ready stream.

Before it is measured, the input passes through a two-flop synchroniser and a glitch filter. The filter ignores pulses that are too short, with the threshold set in base-clock cycles. A capture begins at the first filtered edge after the unit is enabled. It ends when the input stays at one level for longer than a programmable idle limit. The frame then closes with an item flagged as the last one, and that item carries a zero-duration half as the end marker. When the consumer stalls, the item already presented is held. If another item completes during the stall, that item is dropped and a sticky overflow flag is raised.

Top module: `pulse_capture`

## Requirements
- R1: An item packs two halves. Bits [14:0] are the first duration and bit 15 is its level. Bits [30:16] are the second duration and bit 31 is its level. The earlier recorded run sits in the lower half.
- R2: While enabled, the first filtered edge starts a frame, and the level held before that edge is not recorded. Every later run is recorded with the level it held and the number of ticks it lasted.
- R3: With div_i = N > 0, a tick occurs once every N base cycles, so a run of N*k cycles measures k. When div_i = 0, no tick occurs, no frame starts and no item is produced.
- R4: After synchronisation, a change of level is accepted only once it has persisted for flt_i+1 base cycles. A pulse of flt_i cycles or fewer changes no recorded duration and produces no record.
- R5: A run lasting more than idle_i ticks ends the frame. That run is not recorded, and the final item of the frame carries last_o = 1. All other items carry last_o = 0.
- R6: At the end of a frame, a pending half is emitted with a zero upper half. When no half is pending, an all-zero item is emitted.
- R7: A run duration saturates at 0x7FFF.
- R8: Driving en_i low aborts the frame and discards any pending half. The next frame starts fresh.
- R9: While valid_o = 1 and ready_i = 0, item_o and last_o hold their values.
- R10: An item that completes while a stalled item is held is dropped and sets ovf_o. ovf_o stays set until en_i goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Capture enable (start/stop) |
| div_i | input | DIV_W | Tick divider; 0 disables capture |
| flt_i | input | FLT_W | Glitch threshold in base cycles |
| idle_i | input | IDLE_W | Idle limit in ticks |
| sig_i | input | 1 | Asynchronous waveform input |
| item_o | output | 32 | Packed pair of level/duration halves |
| valid_o | output | 1 | item_o is valid |
| last_o | output | 1 | item_o closes the frame |
| ready_i | input | 1 | Consumer accepts item_o |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench keeps the default widths, with an 8-bit divider, an 8-bit filter threshold and a 16-bit idle limit.

It sweeps frames of one to five runs under divider 1 with filter thresholds 0 and 3. This covers odd and even run counts, and so both end-marker forms. It also includes pulses that sit exactly at the filter threshold.

Divider 4 with an idle limit of 10 ticks shows that durations scale with the divider. Divider 0 shows that capture is refused. An idle limit of 0xFFFF makes a single run longer than 0x7FFF ticks reachable, which exposes the saturation.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int DUR_W  = 15;
  localparam int HALF_W = DUR_W + 1;
  localparam int ITEM_W = 2 * HALF_W;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  typedef struct packed {
    logic             lvl;
    logic [DUR_W-1:0] dur;
  } half_t;
endpackage

// File: rtl/pc_prescaler.sv
module pc_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             active;

  assign active = en_i && (div_i != '0);
  assign lim    = div_i - DIV_W'(1);
  assign tick_o = active && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/pc_glitch_filter.sv
module pc_glitch_filter #(
  parameter int FLT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic [FLT_W-1:0] thr_i,
  output logic             lvl_o
);
  logic [1:0]       sync_q;
  logic [FLT_W-1:0] cnt_q;
  logic             lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sig_i};
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= thr_i) begin
        // change persisted thr+1 cycles
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + FLT_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pc_run_meter.sv
module pc_run_meter
  import pc_pkg::*;
#(
  parameter int IDLE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic              lvl_i,
  input  logic [IDLE_W-1:0] idle_i,
  output logic              emit_o,
  output logic [ITEM_W-1:0] emit_item_o,
  output logic              emit_last_o
);
  logic              run_q;
  logic              lvl_q;
  logic [DUR_W-1:0]  dur_q;
  logic [IDLE_W-1:0] idle_q;
  half_t             half_q;
  logic              have_q;
  logic              edge_hit;
  logic              idle_hit;
  half_t             rec;

  assign edge_hit = lvl_i != lvl_q;
  assign idle_hit = run_q && !edge_hit && tick_i && (idle_q >= idle_i);
  assign rec      = '{lvl: lvl_q, dur: dur_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      lvl_q  <= 1'b0;
      dur_q  <= '0;
      idle_q <= '0;
      half_q <= '0;
      have_q <= 1'b0;
    end else if (!act_i) begin
      run_q  <= 1'b0;
      lvl_q  <= lvl_i;
      dur_q  <= '0;
      idle_q <= '0;
      have_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (edge_hit) begin
        run_q  <= 1'b1;
        dur_q  <= DUR_W'(tick_i);
        idle_q <= IDLE_W'(tick_i);
        if (run_q) begin
          if (!have_q) begin
            half_q <= rec;
            have_q <= 1'b1;
          end else begin
            have_q <= 1'b0;
          end
        end
      end else if (idle_hit) begin
        run_q  <= 1'b0;
        have_q <= 1'b0;
      end else if (run_q && tick_i) begin
        if (dur_q != DUR_MAX) dur_q <= dur_q + DUR_W'(1);
        if (idle_q != '1)     idle_q <= idle_q + IDLE_W'(1);
      end
    end
  end

  always_comb begin
    emit_o      = act_i && ((edge_hit && run_q && have_q) || idle_hit);
    emit_last_o = !edge_hit;
    if (edge_hit)    emit_item_o = {rec, half_q};
    else if (have_q) emit_item_o = {HALF_W'(0), half_q};
    else             emit_item_o = '0;
  end
endmodule

// File: rtl/pulse_capture.sv
module pulse_capture
  import pc_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FLT_W  = 8,
  parameter int IDLE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FLT_W-1:0]  flt_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              sig_i,
  output logic [ITEM_W-1:0] item_o,
  output logic              valid_o,
  output logic              last_o,
  input  logic              ready_i,
  output logic              ovf_o
);
  logic              tick;
  logic              act;
  logic              flt_lvl;
  logic              emit;
  logic [ITEM_W-1:0] emit_item;
  logic              emit_last;
  logic [ITEM_W-1:0] item_q;
  logic              valid_q, last_q, ovf_q;

  assign act = en_i && (div_i != '0);

  pc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .en_i, .div_i, .tick_o(tick)
  );

  pc_glitch_filter #(.FLT_W(FLT_W)) u_flt (
    .clk_i, .rst_ni, .sig_i, .thr_i(flt_i), .lvl_o(flt_lvl)
  );

  pc_run_meter #(.IDLE_W(IDLE_W)) u_meter (
    .clk_i, .rst_ni, .act_i(act), .tick_i(tick), .lvl_i(flt_lvl),
    .idle_i, .emit_o(emit), .emit_item_o(emit_item), .emit_last_o(emit_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      item_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (emit && (!valid_q || ready_i)) begin
      item_q  <= emit_item;
      last_q  <= emit_last;
      valid_q <= 1'b1;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ovf_q <= 1'b0;
    else if (!en_i)                        ovf_q <= 1'b0;
    else if (emit && valid_q && !ready_i)  ovf_q <= 1'b1;
  end

  assign item_o  = item_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [DIV_W-1:0] div_i,
  input logic [31:0]      item_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             ready_i,
  input logic             ovf_o,
  input logic             tick
);
  // R9
  hold_item_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(item_o) && $stable(last_o));

  // R10
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(valid_o && !ready_i));

  // R10
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ovf_o);

  // R3
  no_tick_div0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |-> !tick);

  // R6
  end_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o |-> item_o[30:16] == 15'd0);
endmodule

bind pulse_capture pc_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_i(div_i),
  .item_o(item_o), .valid_o(valid_o), .last_o(last_o),
  .ready_i(ready_i), .ovf_o(ovf_o), .tick(tick)
);

// File: tb/pulse_capture_bench.sv
module pulse_capture_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div = 8'd1;
  logic [7:0]  flt = 8'd0;
  logic [15:0] idle = 16'd50;
  logic        sig = 1'b0;
  logic [31:0] item;
  logic        valid, last, ready = 1'b1, ovf;

  int checks = 0;
  int fails  = 0;

  logic [32:0] got[$];
  int seg_lv[32];
  int seg_ln[32];
  int nseg;
  int hv_l[32];
  int hv_d[32];
  int nh;

  always #2.5 clk = ~clk;

  pulse_capture u_pulse_capture (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .div_i(div), .flt_i(flt),
    .idle_i(idle), .sig_i(sig), .item_o(item), .valid_o(valid),
    .last_o(last), .ready_i(ready), .ovf_o(ovf)
  );

  always @(negedge clk) if (valid && ready) got.push_back({last, item});

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart(input int d, input int f, input int i);
    en = 1'b0; sig = 1'b0;
    cyc(8);
    div = 8'(d); flt = 8'(f); idle = 16'(i);
    got.delete();
    en = 1'b1;
    cyc(6);
  endtask

  task automatic play(input int hold);
    for (int k = 0; k < nseg; k++) begin
      sig = seg_lv[k][0];
      cyc(seg_ln[k]);
    end
    sig = ~sig;
    cyc(hold);
  endtask

  task automatic compare(input string req);
    logic [32:0] exp[$];
    logic [15:0] h0, h1;
    for (int k = 0; k < nh; k += 2) begin
      h0 = {hv_l[k][0], 15'(hv_d[k])};
      if (k + 1 < nh) begin
        h1 = {hv_l[k+1][0], 15'(hv_d[k+1])};
        exp.push_back({1'b0, h1, h0});
      end else begin
        exp.push_back({1'b1, 16'h0, h0});
      end
    end
    if (nh % 2 == 0) exp.push_back({1'b1, 32'h0});
    chk(got.size() == exp.size(), {req, " item count"}, got.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got.size(); k++)
      chk(got[k] == exp[k], req, got[k], exp[k]);
  endtask

  initial begin
    cyc(4);
    // reset state
    chk(valid == 1'b0 && ovf == 1'b0 && last == 1'b0, "R1 reset", {valid, ovf, last}, 0);
    rst_ni = 1'b1;
    cyc(3);

    // R1 R2 R5 R6 R4: sweep run counts and filter thresholds, divider 1
    for (int f = 0; f <= 3; f += 3) begin
      for (int n = 1; n <= 5; n++) begin
        restart(1, f, 50);
        nseg = n; nh = n;
        for (int k = 0; k < n; k++) begin
          seg_lv[k] = (k % 2 == 0) ? 1 : 0;
          seg_ln[k] = (f == 3 && k == 0) ? 4 : 5 + ((k * 7 + n * 3) % 20);
          hv_l[k] = seg_lv[k];
          hv_d[k] = seg_ln[k];
        end
        play(90);
        compare("R2 R5 R6 sweep");
      end
    end

    // R4: threshold-length glitch inside a low run is ignored
    restart(1, 3, 50);
    nseg = 5;
    seg_lv[0] = 1; seg_ln[0] = 20;
    seg_lv[1] = 0; seg_ln[1] = 8;
    seg_lv[2] = 1; seg_ln[2] = 3;
    seg_lv[3] = 0; seg_ln[3] = 9;
    seg_lv[4] = 1; seg_ln[4] = 15;
    nh = 3;
    hv_l[0] = 1; hv_d[0] = 20;
    hv_l[1] = 0; hv_d[1] = 20;
    hv_l[2] = 1; hv_d[2] = 15;
    play(90);
    compare("R4 glitch");

    // R3: divider 4, idle 10 ticks
    for (int n = 2; n <= 3; n++) begin
      restart(4, 0, 10);
      nseg = n; nh = n;
      for (int k = 0; k < n; k++) begin
        seg_lv[k] = (k % 2 == 0) ? 1 : 0;
        seg_ln[k] = 4 * (2 + ((k + n) % 7));
        hv_l[k] = seg_lv[k];
        hv_d[k] = seg_ln[k] / 4;
      end
      play(120);
      compare("R3 divider 4");
    end

    // R3: divider 0 produces nothing
    restart(0, 0, 10);
    for (int k = 0; k < 6; k++) begin sig = ~sig; cyc(10); end
    cyc(100);
    chk(got.size() == 0 && valid == 1'b0, "R3 div zero", got.size(), 0);

    // R7: saturation
    restart(1, 0, 16'hFFFF);
    sig = 1'b1; cyc(40000);
    sig = 1'b0; cyc(10);
    sig = 1'b1; cyc(20);
    en = 1'b0; cyc(4);
    chk(got.size() == 1, "R7 count", got.size(), 1);
    if (got.size() > 0)
      chk(got[0] == {1'b0, 1'b0, 15'd10, 1'b1, 15'h7FFF}, "R7 saturate", got[0],
          {1'b0, 1'b0, 15'd10, 1'b1, 15'h7FFF});

    // R8: stop discards a pending half
    restart(1, 0, 50);
    sig = 1'b1; cyc(20);
    sig = 1'b0; cyc(5);
    en = 1'b0; cyc(100);
    chk(got.size() == 0 && valid == 1'b0, "R8 stop no item", got.size(), 0);
    restart(1, 0, 50);
    nseg = 2; nh = 2;
    seg_lv[0] = 1; seg_ln[0] = 12; hv_l[0] = 1; hv_d[0] = 12;
    seg_lv[1] = 0; seg_ln[1] = 7;  hv_l[1] = 0; hv_d[1] = 7;
    play(90);
    compare("R8 fresh frame");

    // R9 R10: stall, hold, overflow
    restart(1, 0, 50);
    ready = 1'b0;
    nseg = 4;
    for (int k = 0; k < 4; k++) begin seg_lv[k] = (k % 2 == 0) ? 1 : 0; seg_ln[k] = 10 + k; end
    play(90);
    chk(valid == 1'b1, "R9 held valid", valid, 1);
    chk(item == {1'b0, 15'd11, 1'b1, 15'd10}, "R9 held item", item, {1'b0, 15'd11, 1'b1, 15'd10});
    chk(ovf == 1'b1, "R10 ovf set", ovf, 1);
    @(negedge clk); ready = 1'b1;
    cyc(5);
    chk(got.size() == 1, "R10 dropped items", got.size(), 1);
    chk(ovf == 1'b1, "R10 ovf sticky", ovf, 1);
    en = 1'b0; cyc(2);
    chk(ovf == 1'b0, "R10 ovf cleared", ovf, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule